// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block holds the time-of-day and calendar registers of a real-time clock and keeps them counting. A one-cycle strobe on `sec_tick`, raised once per second by an external divider, advances the time; seconds, minutes, hours, date, month and a two-digit year carry into one another in BCD order. The weekday advances at midnight. The month length comes from a fixed table, with February given a leap day in years divisible by four.

Software reaches the eight registers through a byte-wide port. `addr` selects a register. With `wr_en` high, `wdata` is written on the rising clock edge. `rdata` always shows the selected register in BCD. The top bit of the seconds register is a stop flag: while it is set, the clock holds its value. A field write whose BCD value is out of range for that field leaves the field unchanged. The weekday register also stores a century flag that software sets and clears. The control register always reads back with certain bits forced to fixed values.

Top module: `rtc_bcd_clock`

## Requirements
- R1: Register addresses are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month and 7 year. After reset they read 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00, in that address order.
- R2: A seconds write always stores wdata bit 7 as the stop flag. It loads wdata bits 6:0 as the seconds only if both BCD digits are valid and the value is 0 to 59. A seconds read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R3: While the stop flag is set, ticks change no register. After the flag is cleared, counting resumes from the held value.
- R4: A minutes write takes BCD from wdata bits 6:0 and is accepted for 0 to 59. An hours write takes BCD from wdata bits 5:0 and is accepted for 0 to 23. A rejected write leaves the field unchanged.
- R5: A weekday write stores wdata bits 2:0 as the weekday and wdata bit 6 as the century flag. A weekday read returns the century flag in bit 6, the weekday in bits 2:0, and zero in all other bits.
- R6: A date write takes BCD from wdata bits 5:0 and is accepted for 1 to 31. A month write takes BCD from wdata bits 4:0 and is accepted for 1 to 12. A year write takes all 8 bits as two BCD digits, 00 to 99. A rejected write leaves the field unchanged.
- R7: A control write stores (wdata AND 0x5F) OR 0x90, so bits 7 and 4 read as 1 and bit 5 reads as 0.
- R8: When the stop flag is clear, each tick adds one to seconds. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours.
- R9: Hours roll from 23 to 0. That carry advances the date and the weekday; the weekday goes from 7 to 1, and any other weekday value goes up by one.
- R10: A date carry rolls the date to 1 and advances the month when the date is at or above the month length. The month length is 30 for months 4, 6, 9 and 11, 31 for the other months, and 29 for February when year mod 4 is 0, otherwise 28.
- R11: The month rolls from 12 to 1 and carries into the year. The year rolls from 99 to 00.
- R12: A tick in a cycle that also has a write is dropped: the write is applied and no register advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the register selected by addr |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |

## Verification
The hardest cases to reach are the carry chains at the end of a month and of the century. From reset they need millions of ticks, so the bench writes each field to its last legal value and then sends a single tick. This is done for a leap and a non-leap February, a 30-day month and year 99 in December. The bench also holds the stop flag during ticks and sends a write in the same cycle as a tick. A long seeded random run then mixes legal and illegal writes with ticks and compares every register against a software calendar model.

// File: rtl/rtc_bcd_pkg.sv
`timescale 1ns/1ps
package rtc_bcd_pkg;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_SEC  = 3'd1,
      REG_MIN  = 3'd2,
      REG_HOUR = 3'd3,
      REG_WDAY = 3'd4,
      REG_DATE = 3'd5,
      REG_MON  = 3'd6,
      REG_YEAR = 3'd7
   } rtc_reg_e;

   typedef struct packed {
      logic       ld_ctrl;
      logic [7:0] ctrl;
      logic       ld_stop;
      logic       stop;
      logic       ld_sec;
      logic [6:0] sec;
      logic       ld_min;
      logic [6:0] min;
      logic       ld_hour;
      logic [6:0] hour;
      logic       ld_wday;
      logic [2:0] wday;
      logic       cent;
      logic       ld_date;
      logic [6:0] date;
      logic       ld_mon;
      logic [6:0] mon;
      logic       ld_year;
      logic [6:0] year;
   } rtc_wr_cmd_t;

   function automatic logic digits_ok(input logic [7:0] b);
      return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
   endfunction

   function automatic logic [6:0] bcd2bin(input logic [7:0] b);
      return ({3'd0, b[7:4]} * 7'd10) + {3'd0, b[3:0]};
   endfunction

   function automatic logic [7:0] bin2bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

endpackage

// File: rtl/rtc_cnt_field.sv
`timescale 1ns/1ps
module rtc_cnt_field #(
   parameter int W       = 7,
   parameter int MIN_V   = 0,
   parameter int MAX_V   = 59,
   parameter int WRAP_V  = 0,
   parameter int RST_V   = 0,
   parameter bit DYN_MAX = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   input  logic [W-1:0] dyn_lim,
   output logic [W-1:0] q,
   output logic         carry
);

   localparam logic [W-1:0] MAX_Q  = W'(MAX_V);
   localparam logic [W-1:0] MIN_Q  = W'(MIN_V);
   localparam logic [W-1:0] WRAP_Q = W'(WRAP_V);
   localparam logic [W-1:0] RST_Q  = W'(RST_V);

   generate
      if (MAX_V >= (1 << W)) begin : g_bad_width
         $error("rtc_cnt_field: MAX_V does not fit in W bits");
      end
      if (RST_V < MIN_V || RST_V > MAX_V) begin : g_bad_rst
         $error("rtc_cnt_field: RST_V outside the legal range");
      end
      if (WRAP_V < MIN_V || WRAP_V > MAX_V) begin : g_bad_wrap
         $error("rtc_cnt_field: WRAP_V outside the legal range");
      end
   endgenerate

   logic [W-1:0] lim;
   assign lim   = DYN_MAX ? dyn_lim : MAX_Q;
   assign carry = inc && (q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= RST_Q;
      else if (ld)    q <= ld_val;
      else if (carry) q <= WRAP_Q;
      else if (inc)   q <= q + 1'b1;
   end

   AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && !ld) |=> (q == WRAP_Q)); // R8

   AST_FIELD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      q <= MAX_Q); // R6

   generate
      if (MIN_V > 0) begin : g_min_chk
         AST_FIELD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            q >= MIN_Q); // R6
      end
   endgenerate

endmodule

// File: rtl/rtc_month_len.sv
`timescale 1ns/1ps
module rtc_month_len #(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic [6:0] month,
   input  logic [1:0] year_lo,
   output logic [6:0] days
);

   logic leap;
   assign leap = LEAP_EN && (year_lo == 2'd0);

   always_comb begin
      case (month)
         7'd4, 7'd6, 7'd9, 7'd11: days = 7'd30;
         7'd2:                    days = leap ? 7'd29 : 7'd28;
         default:                 days = 7'd31;
      endcase
   end

endmodule

// File: rtl/rtc_wr_decode.sv
`timescale 1ns/1ps
module rtc_wr_decode
   import rtc_bcd_pkg::*;
(
   input  logic        wr_en,
   input  logic [2:0]  addr,
   input  logic [7:0]  wdata,
   output rtc_wr_cmd_t cmd
);

   logic [7:0] f_sec, f_hour, f_date, f_mon;
   logic [6:0] v_sec, v_hour, v_date, v_mon, v_year;

   assign f_sec  = {1'b0, wdata[6:0]};
   assign f_hour = {2'b0, wdata[5:0]};
   assign f_date = {2'b0, wdata[5:0]};
   assign f_mon  = {3'b0, wdata[4:0]};

   assign v_sec  = bcd2bin(f_sec);
   assign v_hour = bcd2bin(f_hour);
   assign v_date = bcd2bin(f_date);
   assign v_mon  = bcd2bin(f_mon);
   assign v_year = bcd2bin(wdata);

   always_comb begin
      cmd      = '0;
      cmd.ctrl = (wdata & 8'h5F) | 8'h90;
      cmd.stop = wdata[7];
      cmd.sec  = v_sec;
      cmd.min  = v_sec;
      cmd.hour = v_hour;
      cmd.wday = wdata[2:0];
      cmd.cent = wdata[6];
      cmd.date = v_date;
      cmd.mon  = v_mon;
      cmd.year = v_year;
      if (wr_en) begin
         case (addr)
            REG_CTRL: cmd.ld_ctrl = 1'b1;
            REG_SEC: begin
               cmd.ld_stop = 1'b1;
               cmd.ld_sec  = digits_ok(f_sec) && (v_sec <= 7'd59);
            end
            REG_MIN:  cmd.ld_min  = digits_ok(f_sec) && (v_sec <= 7'd59);
            REG_HOUR: cmd.ld_hour = digits_ok(f_hour) && (v_hour <= 7'd23);
            REG_WDAY: cmd.ld_wday = 1'b1;
            REG_DATE: cmd.ld_date = digits_ok(f_date) && (v_date >= 7'd1) && (v_date <= 7'd31);
            REG_MON:  cmd.ld_mon  = digits_ok(f_mon) && (v_mon >= 7'd1) && (v_mon <= 7'd12);
            default:  cmd.ld_year = digits_ok(wdata);
         endcase
      end
   end

endmodule

// File: rtl/rtc_bcd_clock.sv
`timescale 1ns/1ps
module rtc_bcd_clock
   import rtc_bcd_pkg::*;
#(
   parameter bit         LEAP_EN  = 1'b1,
   parameter logic [7:0] CTRL_RST = 8'h90
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       wr_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata
);

   generate
      if (!CTRL_RST[7] || !CTRL_RST[4] || CTRL_RST[5]) begin : g_bad_ctrl
         $error("rtc_bcd_clock: CTRL_RST must have bits 7,4 set and bit 5 clear");
      end
   endgenerate

   rtc_wr_cmd_t cmd;
   logic [7:0]  ctrl_q;
   logic        stop_q, cent_q;
   logic [6:0]  sec_q, min_q, hour_q, date_q, mon_q, year_q, mdays;
   logic [2:0]  wday_q;
   logic        tick_ok, c_sec, c_min, c_hour, c_date, c_mon, c_year, c_wday;

   rtc_wr_decode u_dec (.wr_en(wr_en), .addr(addr), .wdata(wdata), .cmd(cmd));

   assign tick_ok = sec_tick && !stop_q && !wr_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         stop_q <= 1'b0;
         cent_q <= 1'b0;
      end else begin
         if (cmd.ld_ctrl) ctrl_q <= cmd.ctrl;
         if (cmd.ld_stop) stop_q <= cmd.stop;
         if (cmd.ld_wday) cent_q <= cmd.cent;
      end
   end

   rtc_cnt_field #(.W(7), .MIN_V(0), .MAX_V(59), .WRAP_V(0), .RST_V(0)) u_sec (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_sec), .ld_val(cmd.sec),
      .inc(tick_ok), .dyn_lim(7'd0), .q(sec_q), .carry(c_sec));

   rtc_cnt_field #(.W(7), .MIN_V(0), .MAX_V(59), .WRAP_V(0), .RST_V(0)) u_min (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_min), .ld_val(cmd.min),
      .inc(c_sec), .dyn_lim(7'd0), .q(min_q), .carry(c_min));

   rtc_cnt_field #(.W(7), .MIN_V(0), .MAX_V(23), .WRAP_V(0), .RST_V(0)) u_hour (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_hour), .ld_val(cmd.hour),
      .inc(c_min), .dyn_lim(7'd0), .q(hour_q), .carry(c_hour));

   rtc_cnt_field #(.W(3), .MIN_V(0), .MAX_V(7), .WRAP_V(1), .RST_V(1)) u_wday (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_wday), .ld_val(cmd.wday),
      .inc(c_hour), .dyn_lim(3'd0), .q(wday_q), .carry(c_wday));

   rtc_month_len #(.LEAP_EN(LEAP_EN)) u_mlen (
      .month(mon_q), .year_lo(year_q[1:0]), .days(mdays));

   rtc_cnt_field #(.W(7), .MIN_V(1), .MAX_V(31), .WRAP_V(1), .RST_V(1), .DYN_MAX(1'b1)) u_date (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_date), .ld_val(cmd.date),
      .inc(c_hour), .dyn_lim(mdays), .q(date_q), .carry(c_date));

   rtc_cnt_field #(.W(7), .MIN_V(1), .MAX_V(12), .WRAP_V(1), .RST_V(1)) u_mon (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_mon), .ld_val(cmd.mon),
      .inc(c_date), .dyn_lim(7'd0), .q(mon_q), .carry(c_mon));

   rtc_cnt_field #(.W(7), .MIN_V(0), .MAX_V(99), .WRAP_V(0), .RST_V(0)) u_year (
      .clk(clk), .rst_n(rst_n), .ld(cmd.ld_year), .ld_val(cmd.year),
      .inc(c_mon), .dyn_lim(7'd0), .q(year_q), .carry(c_year));

   always_comb begin
      case (addr)
         REG_CTRL: rdata = ctrl_q;
         REG_SEC:  rdata = {stop_q, 7'(bin2bcd(sec_q))};
         REG_MIN:  rdata = bin2bcd(min_q);
         REG_HOUR: rdata = bin2bcd(hour_q);
         REG_WDAY: rdata = {1'b0, cent_q, 3'b000, wday_q};
         REG_DATE: rdata = bin2bcd(date_q);
         REG_MON:  rdata = bin2bcd(mon_q);
         default:  rdata = bin2bcd(year_q);
      endcase
   end

   AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !wr_en) |=> $stable(sec_q)); // R3

   AST_CTRL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5])); // R7

   AST_BAD_MONTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_MON && !cmd.ld_mon) |=> $stable(mon_q)); // R6

   AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sec_tick && addr != REG_SEC) |=> $stable(sec_q)); // R12

   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (c_year && !cmd.ld_year) |=> (year_q == 7'd0)); // R11

   AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (c_wday && !cmd.ld_wday) |=> (wday_q == 3'd1)); // R9

endmodule

// File: tb/rtc_bcd_clock_tb.sv
`timescale 1ns/1ps
module rtc_bcd_clock_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   int   m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr;
   bit   m_stop, m_cent;
   logic [7:0] m_ctrl;

   always #2 clk = ~clk;

   rtc_bcd_clock u_dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mdays(input int mo, input int yr);
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      return 31;
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0: return "R7";
         1: return "R2";
         2, 3: return "R4";
         4: return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input int a);
      case (a)
         0: return m_ctrl;
         1: return {m_stop, 7'(to_bcd(m_sec))};
         2: return to_bcd(m_min);
         3: return to_bcd(m_hr);
         4: return {1'b0, m_cent, 3'b000, 3'(m_wd)};
         5: return to_bcd(m_date);
         6: return to_bcd(m_mon);
         default: return to_bcd(m_yr);
      endcase
   endfunction

   task automatic model_reset();
      m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_date = 1; m_mon = 1; m_yr = 0;
      m_stop = 0; m_cent = 0; m_ctrl = 8'h90;
   endtask

   task automatic model_update(input bit wr, input int a, input logic [7:0] d, input bit tk);
      int hi, lo, v;
      if (wr) begin
         case (a)
            0: m_ctrl = (d & 8'h5F) | 8'h90;
            1, 2: begin
               hi = int'(d[6:4]); lo = int'(d[3:0]); v = hi * 10 + lo;
               if (a == 1) m_stop = d[7];
               if (lo <= 9 && v <= 59) begin
                  if (a == 1) m_sec = v; else m_min = v;
               end
            end
            3: begin
               hi = int'(d[5:4]); lo = int'(d[3:0]); v = hi * 10 + lo;
               if (lo <= 9 && v <= 23) m_hr = v;
            end
            4: begin m_wd = int'(d[2:0]); m_cent = d[6]; end
            5: begin
               hi = int'(d[5:4]); lo = int'(d[3:0]); v = hi * 10 + lo;
               if (lo <= 9 && v >= 1 && v <= 31) m_date = v;
            end
            6: begin
               hi = int'(d[4]); lo = int'(d[3:0]); v = hi * 10 + lo;
               if (lo <= 9 && v >= 1 && v <= 12) m_mon = v;
            end
            default: begin
               hi = int'(d[7:4]); lo = int'(d[3:0]);
               if (hi <= 9 && lo <= 9) m_yr = hi * 10 + lo;
            end
         endcase
      end else if (tk && !m_stop) begin
         if (m_sec == 59) begin
            m_sec = 0;
            if (m_min == 59) begin
               m_min = 0;
               if (m_hr == 23) begin
                  m_hr = 0;
                  m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                  if (m_date >= mdays(m_mon, m_yr)) begin
                     m_date = 1;
                     if (m_mon == 12) begin
                        m_mon = 1;
                        m_yr = (m_yr == 99) ? 0 : m_yr + 1;
                     end else m_mon++;
                  end else m_date++;
               end else m_hr++;
            end else m_min++;
         end else m_sec++;
      end
   endtask

   task automatic step(input bit wr, input int a, input logic [7:0] d, input bit tk);
      @(negedge clk);
      wr_en = wr; addr = 3'(a); wdata = d; sec_tick = tk;
      @(posedge clk);
      model_update(wr, a, d, tk);
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      step(1'b1, a, d, 1'b0);
   endtask

   task automatic tick();
      step(1'b0, 0, 8'h00, 1'b1);
   endtask

   task automatic chk_val(input int a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      wr_en = 1'b0; sec_tick = 1'b0; addr = 3'(a);
      #1;
      n_chk++;
      if (rdata !== exp) begin
         n_err++;
         $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rdata, exp);
      end
   endtask

   task automatic chk_model(input int a, input string tag);
      chk_val(a, exp_read(a), tag);
   endtask

   task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
      wr(7, yr); wr(6, mo); wr(5, dt); wr(3, hr); wr(2, mi); wr(1, se);
   endtask

   function automatic logic [7:0] gen_data(input int a);
      if ($urandom % 5 < 2) return 8'($urandom);
      case (a)
         0, 4: return 8'($urandom);
         1: return to_bcd($urandom_range(50, 59)) | {1'($urandom % 3 == 0), 7'd0};
         2: return to_bcd($urandom_range(55, 59));
         3: return to_bcd($urandom_range(20, 23));
         5: return to_bcd($urandom_range(26, 31));
         6: return to_bcd($urandom_range(1, 12));
         default: return to_bcd($urandom_range(95, 99));
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd4817));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values
      chk_val(0, 8'h90, "R1"); chk_val(1, 8'h00, "R1"); chk_val(2, 8'h00, "R1");
      chk_val(3, 8'h00, "R1"); chk_val(4, 8'h01, "R1"); chk_val(5, 8'h01, "R1");
      chk_val(6, 8'h01, "R1"); chk_val(7, 8'h00, "R1");

      // R7 control forcing
      wr(0, 8'hFF); chk_val(0, 8'hDF, "R7");
      wr(0, 8'h00); chk_val(0, 8'h90, "R7");

      // R2 seconds writes and stop flag
      wr(1, 8'h45); chk_val(1, 8'h45, "R2");
      wr(1, 8'h5A); chk_val(1, 8'h45, "R2");
      wr(1, 8'h60); chk_val(1, 8'h45, "R2");
      wr(1, 8'h92); chk_val(1, 8'h92, "R2");
      wr(1, 8'hE0); chk_val(1, 8'h92, "R2");

      // R3 stop freezes, clearing resumes
      tick(); tick(); tick(); chk_val(1, 8'h92, "R3");
      wr(1, 8'h12); tick(); chk_val(1, 8'h13, "R3");

      // R4 minutes and hours
      wr(2, 8'h59); chk_val(2, 8'h59, "R4");
      wr(2, 8'h60); chk_val(2, 8'h59, "R4");
      wr(3, 8'h23); wr(3, 8'h24); chk_val(3, 8'h23, "R4");
      wr(3, 8'hC7); chk_val(3, 8'h07, "R4");

      // R5 weekday and century
      wr(4, 8'h47); chk_val(4, 8'h47, "R5");
      wr(4, 8'hFF); chk_val(4, 8'h47, "R5");
      wr(4, 8'h05); chk_val(4, 8'h05, "R5");
      wr(4, 8'h47);

      // R6 date, month, year
      wr(7, 8'h03); wr(6, 8'h02); wr(6, 8'h13); wr(6, 8'h00); chk_val(6, 8'h02, "R6");
      wr(5, 8'h28); wr(5, 8'h32); wr(5, 8'h00); chk_val(5, 8'h28, "R6");
      wr(7, 8'hA0); chk_val(7, 8'h03, "R6");

      // R8 R9 R10 non-leap February end
      set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick();
      chk_val(1, 8'h00, "R8"); chk_val(2, 8'h00, "R8"); chk_val(3, 8'h00, "R9");
      chk_val(4, 8'h41, "R9"); chk_val(5, 8'h01, "R10"); chk_val(6, 8'h03, "R10");

      // R10 leap February
      set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick();
      chk_val(5, 8'h29, "R10"); chk_val(6, 8'h02, "R10");
      set_time(8'h04, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); tick();
      chk_val(5, 8'h01, "R10"); chk_val(6, 8'h03, "R10");

      // R10 thirty-day month
      set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); tick();
      chk_val(5, 8'h01, "R10"); chk_val(6, 8'h05, "R10");

      // R11 century wrap
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); tick();
      chk_val(7, 8'h00, "R11"); chk_val(6, 8'h01, "R11"); chk_val(5, 8'h01, "R11");

      // R12 write in tick cycle
      wr(1, 8'h10);
      step(1'b1, 2, 8'h05, 1'b1);
      chk_val(1, 8'h10, "R12"); chk_val(2, 8'h05, "R12");

      // seeded random mix
      for (int i = 0; i < 4000; i++) begin
         int a;
         a = $urandom_range(0, 7);
         if ($urandom % 100 < 15) step(1'b1, a, gen_data(a), 1'($urandom % 2));
         else step(1'b0, 0, 8'h00, 1'($urandom % 4 != 0));
         if (i % 40 == 39) begin
            for (int r = 0; r < 8; r++) chk_model(r, tag_of(r));
         end
      end
      for (int r = 0; r < 8; r++) chk_model(r, "R8");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule